// File: doc/BRIEF.md
# Issue Group Former

This block sits between an in-order instruction buffer and the execution pipes of a four-wide issue stage. Each cycle it looks at up to four decoded instructions at the buffer head, oldest first, and decides how many of them leave together as one dispatch group. It also decides which execution pipe each member goes to. The instructions that issue are always a leading run of the window. The first instruction that breaks a grouping rule ends the group, and nothing behind it may overtake it. The buffer pops exactly `issue_cnt` entries on the next clock.

Every instruction carries a class code, a kind code and a destination-file mask. The class decides slot position, functional unit and pipe. The kind flags the few instructions that get special handling: a jump-and-link, long-latency integer operations, condition-code register access, FP compares, and the instructions that must keep clear of an FP compare. The destination mask tracks register-file write ports. Three timers hold state between cycles. The first stalls all issue for a programmed number of cycles after a long operation. The second keeps compare-sensitive instructions out for a short window after an FP compare. The third delays a condition-code read until it has waited a fixed time at the buffer head.

Top module: `issue_group_former`

## Requirements
- R1: Window slot k uses bits [4k+3:4k] of `in_cls`, [3k+2:3k] of `in_kind` and [2k+1:2k] of `in_dst`. A slot with `in_valid` low, or one that breaks any rule, ends the group. `issue_cnt` (0 to 4) counts the leading slots that issue, and no later slot issues past the blocked one.
- R2: Class codes are 0 = integer on either ALU, 1 = ALU0-only (shift), 2 = ALU1-only (cc-setting), 5 = load and 6 = store. Instructions of these classes may occupy only group positions 0 to 2.
- R3: A group holds at most two ALU-class instructions (classes 0 to 2), at most one of class 1 and at most one of class 2. A class 0 instruction goes to ALU0 unless the group contains a class 1 instruction or an earlier class 0 instruction already took ALU0. In those cases it goes to ALU1.
- R4: A group holds one load/store at most. Classes 5 and 6 count as load/store, and so does any instruction of kind 1 (jump-and-link).
- R5: A group holds at most one each of class 3 (FP multiply), class 4 (FP add) and class 7 (control transfer). These classes may take any position, including position 3.
- R6: `in_dst` bit 0 marks an integer-file writer and bit 1 an FP-file writer. A group holds at most two integer-file writers and at most one FP-file writer.
- R7: Class 8, and kinds 2 (64-bit divide), 3 (64-bit multiply), 4 (condition-code write) and 5 (condition-code read), are single-issue. They issue only at position 0 and then close the group, so `issue_cnt` is 1.
- R8: After a kind 2 issues, the next 68 cycles issue nothing. A kind 3 blocks the next 19 cycles and a kind 4 the next 4 cycles.
- R9: Kind 6 is an FP compare. Kinds 2, 3 and 7 (FP double store, FP conditional move) may not issue in the same group as a kind 6 or in the 2 cycles after it.
- R10: A kind 5 instruction issues no earlier than the fifth cycle it spends at the window head, which is 4 clocks after it arrives there.
- R11: Each field of `issue_pipe` (3 bits per slot) gives the pipe of an issued slot: 1 = ALU0, 2 = ALU1, 3 = load/store, 4 = FP multiply, 5 = FP add, 6 = branch. Class 8 goes to ALU0. A slot that does not issue reads 0.
- R12: While `rst_n` is low `issue_cnt` is 0. Reset clears all timers, so the first cycle after reset can issue a full group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Window slot holds an instruction |
| in_cls | input | 16 | Class code per slot |
| in_kind | input | 12 | Special-handling kind per slot |
| in_dst | input | 8 | Destination file mask per slot |
| issue_cnt | output | 3 | Number of leading slots issued this cycle |
| issue_pipe | output | 12 | Pipe code per slot |

## Verification
On every cycle the assertions check the structural limits of the chosen group: the issued slots form a prefix, load/store and FP-write ports are used at most once, integer-type classes stay out of the last position, single-issue instructions issue alone, and nothing issues while a stall window or compare window forbids it. They also check that the stall timer is loaded and then counts down. The exact window lengths (68, 19, 4 and 2 cycles, and the 4-clock wait of a condition-code read), the pipe steering of class 0 instructions and the fact that a blocked slot cannot be overtaken depend on whole instruction sequences. Only the bench's reference model and its directed sequences can show these.

// File: rtl/igf_pkg.sv
`timescale 1ns/1ps
package igf_pkg;
  localparam int CLS_W  = 4;
  localparam int KIND_W = 3;
  localparam int DST_W  = 2;
  localparam int PIPE_W = 3;

  localparam logic [CLS_W-1:0] CL_ANY  = 4'd0;
  localparam logic [CLS_W-1:0] CL_ALU0 = 4'd1;
  localparam logic [CLS_W-1:0] CL_ALU1 = 4'd2;
  localparam logic [CLS_W-1:0] CL_FPM  = 4'd3;
  localparam logic [CLS_W-1:0] CL_FPA  = 4'd4;
  localparam logic [CLS_W-1:0] CL_LD   = 4'd5;
  localparam logic [CLS_W-1:0] CL_ST   = 4'd6;
  localparam logic [CLS_W-1:0] CL_CTI  = 4'd7;
  localparam logic [CLS_W-1:0] CL_SOLO = 4'd8;

  localparam logic [KIND_W-1:0] KD_PLAIN  = 3'd0;
  localparam logic [KIND_W-1:0] KD_JMPL   = 3'd1;
  localparam logic [KIND_W-1:0] KD_DIV    = 3'd2;
  localparam logic [KIND_W-1:0] KD_MUL    = 3'd3;
  localparam logic [KIND_W-1:0] KD_WRCC   = 3'd4;
  localparam logic [KIND_W-1:0] KD_RDCC   = 3'd5;
  localparam logic [KIND_W-1:0] KD_FCMP   = 3'd6;
  localparam logic [KIND_W-1:0] KD_FPSENS = 3'd7;

  localparam logic [PIPE_W-1:0] PP_NONE = 3'd0;
  localparam logic [PIPE_W-1:0] PP_ALU0 = 3'd1;
  localparam logic [PIPE_W-1:0] PP_ALU1 = 3'd2;
  localparam logic [PIPE_W-1:0] PP_LSU  = 3'd3;
  localparam logic [PIPE_W-1:0] PP_FPM  = 3'd4;
  localparam logic [PIPE_W-1:0] PP_FPA  = 3'd5;
  localparam logic [PIPE_W-1:0] PP_BRU  = 3'd6;

  function automatic logic is_alu(input logic [CLS_W-1:0] c);
    return (c == CL_ANY) || (c == CL_ALU0) || (c == CL_ALU1);
  endfunction

  function automatic logic is_mem(input logic [CLS_W-1:0] c);
    return (c == CL_LD) || (c == CL_ST);
  endfunction

  function automatic logic forces_solo(input logic [CLS_W-1:0] c, input logic [KIND_W-1:0] k);
    return (c >= CL_SOLO) || (k == KD_DIV) || (k == KD_MUL) || (k == KD_WRCC) || (k == KD_RDCC);
  endfunction

  function automatic logic fcmp_shy(input logic [KIND_W-1:0] k);
    return (k == KD_DIV) || (k == KD_MUL) || (k == KD_FPSENS);
  endfunction

  function automatic logic [PIPE_W-1:0] fixed_pipe(input logic [CLS_W-1:0] c);
    case (c)
      CL_ALU1:       return PP_ALU1;
      CL_FPM:        return PP_FPM;
      CL_FPA:        return PP_FPA;
      CL_LD, CL_ST:  return PP_LSU;
      CL_CTI:        return PP_BRU;
      default:       return PP_ALU0;
    endcase
  endfunction
endpackage

// File: rtl/igf_slot_chain.sv
`timescale 1ns/1ps
module igf_slot_chain
  import igf_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int INT_SLOTS  = 3,
  parameter int MAX_ALU    = 2,
  parameter int MAX_INT_WR = 2,
  parameter int MAX_FP_WR  = 1
) (
  input  logic [SLOTS-1:0]        valid,
  input  logic [SLOTS*CLS_W-1:0]  cls,
  input  logic [SLOTS*KIND_W-1:0] kind,
  input  logic [SLOTS*DST_W-1:0]  dst,
  input  logic                    hold,
  input  logic                    fc_win,
  input  logic                    rd_ready,
  output logic [SLOTS-1:0]        take,
  output logic [$clog2(SLOTS+1)-1:0] cnt,
  output logic [SLOTS*PIPE_W-1:0] pipe
);
  localparam int CW = $clog2(SLOTS+1);
  localparam logic [CW-1:0] ALU_LIM = CW'(MAX_ALU);
  localparam logic [CW-1:0] IW_LIM  = CW'(MAX_INT_WR);
  localparam logic [CW-1:0] FW_LIM  = CW'(MAX_FP_WR);

  // admission: walk the window oldest first, stop at the first refusal
  always_comb begin
    logic stop, ok, fcs, ls_use;
    logic [CW-1:0] n_alu, n_iw, n_fw;
    logic a0, a1, ls, fm, fa, ct;
    logic [CLS_W-1:0] c;
    logic [KIND_W-1:0] kd;
    logic [DST_W-1:0] d;
    stop = hold; fcs = fc_win;
    n_alu = '0; n_iw = '0; n_fw = '0;
    a0 = 1'b0; a1 = 1'b0; ls = 1'b0; fm = 1'b0; fa = 1'b0; ct = 1'b0;
    take = '0; cnt = '0;
    for (int k = 0; k < SLOTS; k++) begin
      c  = cls[k*CLS_W +: CLS_W];
      kd = kind[k*KIND_W +: KIND_W];
      d  = dst[k*DST_W +: DST_W];
      ls_use = is_mem(c) || (kd == KD_JMPL);
      ok = valid[k] && !stop;
      if (forces_solo(c, kd) && k != 0) ok = 1'b0;
      if (kd == KD_RDCC && !rd_ready) ok = 1'b0;
      if ((is_alu(c) || is_mem(c)) && k >= INT_SLOTS) ok = 1'b0;
      if (is_alu(c) && n_alu == ALU_LIM) ok = 1'b0;
      if (c == CL_ALU0 && a0) ok = 1'b0;
      if (c == CL_ALU1 && a1) ok = 1'b0;
      if (ls_use && ls) ok = 1'b0;
      if (c == CL_FPM && fm) ok = 1'b0;
      if (c == CL_FPA && fa) ok = 1'b0;
      if (c == CL_CTI && ct) ok = 1'b0;
      if (d[0] && n_iw == IW_LIM) ok = 1'b0;
      if (d[1] && n_fw == FW_LIM) ok = 1'b0;
      if (fcmp_shy(kd) && fcs) ok = 1'b0;
      if (ok) begin
        take[k] = 1'b1;
        cnt = cnt + 1'b1;
        if (is_alu(c)) n_alu = n_alu + 1'b1;
        if (c == CL_ALU0) a0 = 1'b1;
        if (c == CL_ALU1) a1 = 1'b1;
        if (ls_use) ls = 1'b1;
        if (c == CL_FPM) fm = 1'b1;
        if (c == CL_FPA) fa = 1'b1;
        if (c == CL_CTI) ct = 1'b1;
        if (d[0]) n_iw = n_iw + 1'b1;
        if (d[1]) n_fw = n_fw + 1'b1;
        if (kd == KD_FCMP) fcs = 1'b1;
        if (forces_solo(c, kd)) stop = 1'b1;
      end else begin
        stop = 1'b1;
      end
    end
  end

  // steering: a flexible ALU op yields ALU0 to a pinned one anywhere in the group
  always_comb begin
    logic alu0_busy;
    logic [CLS_W-1:0] c;
    alu0_busy = 1'b0;
    for (int k = 0; k < SLOTS; k++)
      if (take[k] && cls[k*CLS_W +: CLS_W] == CL_ALU0) alu0_busy = 1'b1;
    pipe = '0;
    for (int k = 0; k < SLOTS; k++) begin
      c = cls[k*CLS_W +: CLS_W];
      if (!take[k]) begin
        pipe[k*PIPE_W +: PIPE_W] = PP_NONE;
      end else if (c == CL_ANY) begin
        pipe[k*PIPE_W +: PIPE_W] = alu0_busy ? PP_ALU1 : PP_ALU0;
        alu0_busy = 1'b1;
      end else begin
        pipe[k*PIPE_W +: PIPE_W] = fixed_pipe(c);
      end
    end
  end
endmodule

// File: rtl/igf_hold_timers.sv
`timescale 1ns/1ps
module igf_hold_timers #(
  parameter int BW        = 7,
  parameter int FW        = 2,
  parameter int WW        = 3,
  parameter int FCMP_GAP  = 2,
  parameter int RDCC_WAIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_en,
  input  logic [BW-1:0] blk_val,
  input  logic          fc_issue,
  input  logic          head_rd,
  input  logic          rd_issue,
  output logic          hold,
  output logic          fc_win,
  output logic          rd_ready
);
  localparam logic [WW-1:0] WAIT_LIM = WW'(RDCC_WAIT);
  logic [BW-1:0] blk_q;
  logic [FW-1:0] fc_q;
  logic [WW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      fc_q   <= '0;
      wait_q <= '0;
    end else begin
      if (blk_en)             blk_q <= blk_val;
      else if (blk_q != '0)   blk_q <= blk_q - 1'b1;
      if (fc_issue)           fc_q <= FW'(FCMP_GAP);
      else if (fc_q != '0)    fc_q <= fc_q - 1'b1;
      if (head_rd && !rd_issue) begin
        if (wait_q != WAIT_LIM) wait_q <= wait_q + 1'b1;
      end else begin
        wait_q <= '0;
      end
    end
  end

  assign hold     = (blk_q != '0);
  assign fc_win   = (fc_q != '0);
  assign rd_ready = (wait_q == WAIT_LIM);

  // R8: once loaded, the stall window shrinks by one per cycle
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q != '0 && !blk_en) |=> blk_q == $past(blk_q) - 1'b1);
  // R9: an FP compare opens its window on the next cycle
  a_r9_window_open: assert property (@(posedge clk) disable iff (!rst_n)
    fc_issue |=> fc_win);
  // R10: the head wait never runs past its limit
  a_r10_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= WAIT_LIM);
endmodule

// File: rtl/issue_group_former.sv
`timescale 1ns/1ps
module issue_group_former
  import igf_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int INT_SLOTS  = 3,
  parameter int MAX_ALU    = 2,
  parameter int MAX_INT_WR = 2,
  parameter int MAX_FP_WR  = 1,
  parameter int DIV_GAP    = 68,
  parameter int MUL_GAP    = 19,
  parameter int WRCC_GAP   = 4,
  parameter int FCMP_GAP   = 2,
  parameter int RDCC_WAIT  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            in_valid,
  input  logic [SLOTS*CLS_W-1:0]      in_cls,
  input  logic [SLOTS*KIND_W-1:0]     in_kind,
  input  logic [SLOTS*DST_W-1:0]      in_dst,
  output logic [$clog2(SLOTS+1)-1:0]  issue_cnt,
  output logic [SLOTS*PIPE_W-1:0]     issue_pipe
);
  localparam int GAP_MAX = (DIV_GAP > MUL_GAP) ? ((DIV_GAP > WRCC_GAP) ? DIV_GAP : WRCC_GAP)
                                               : ((MUL_GAP > WRCC_GAP) ? MUL_GAP : WRCC_GAP);
  localparam int BW = $clog2(GAP_MAX + 1);
  localparam int FW = $clog2(FCMP_GAP + 1);
  localparam int WW = $clog2(RDCC_WAIT + 1);

  logic [SLOTS-1:0] take, solo_v, div_v, mul_v, wrcc_v, fcmp_v, rdcc_v, shy_v, mem_v, fpw_v, intpos_v;
  logic hold, fc_win, rd_ready, blk_en, fc_issue, head_rd, rd_issue;
  logic [BW-1:0] blk_val;

  for (genvar g = 0; g < SLOTS; g++) begin : g_flag
    wire [CLS_W-1:0]  c = in_cls[g*CLS_W +: CLS_W];
    wire [KIND_W-1:0] k = in_kind[g*KIND_W +: KIND_W];
    assign solo_v[g]   = forces_solo(c, k);
    assign div_v[g]    = (k == KD_DIV);
    assign mul_v[g]    = (k == KD_MUL);
    assign wrcc_v[g]   = (k == KD_WRCC);
    assign fcmp_v[g]   = (k == KD_FCMP);
    assign rdcc_v[g]   = (k == KD_RDCC);
    assign shy_v[g]    = fcmp_shy(k);
    assign mem_v[g]    = is_mem(c) || (k == KD_JMPL);
    assign fpw_v[g]    = in_dst[g*DST_W + 1];
    assign intpos_v[g] = is_alu(c) || is_mem(c);
  end

  igf_slot_chain #(
    .SLOTS(SLOTS), .INT_SLOTS(INT_SLOTS), .MAX_ALU(MAX_ALU),
    .MAX_INT_WR(MAX_INT_WR), .MAX_FP_WR(MAX_FP_WR)
  ) u_chain (
    .valid(in_valid), .cls(in_cls), .kind(in_kind), .dst(in_dst),
    .hold(hold || !rst_n), .fc_win(fc_win), .rd_ready(rd_ready),
    .take(take), .cnt(issue_cnt), .pipe(issue_pipe)
  );

  always_comb begin
    blk_en  = |(take & (div_v | mul_v | wrcc_v));
    if (|(take & div_v))      blk_val = BW'(DIV_GAP);
    else if (|(take & mul_v)) blk_val = BW'(MUL_GAP);
    else                      blk_val = BW'(WRCC_GAP);
  end
  assign fc_issue = |(take & fcmp_v);
  assign head_rd  = in_valid[0] && rdcc_v[0];
  assign rd_issue = take[0] && rdcc_v[0];

  igf_hold_timers #(
    .BW(BW), .FW(FW), .WW(WW), .FCMP_GAP(FCMP_GAP), .RDCC_WAIT(RDCC_WAIT)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .blk_val(blk_val),
    .fc_issue(fc_issue), .head_rd(head_rd), .rd_issue(rd_issue),
    .hold(hold), .fc_win(fc_win), .rd_ready(rd_ready)
  );

  // R1: issued slots are a leading run of the window
  a_r1_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((take + 1'b1) & take) == '0);
  // R2: the last position never carries an integer or memory class
  a_r2_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
    !(take[SLOTS-1] && intpos_v[SLOTS-1]));
  // R4: one load/store slot per group
  a_r4_one_mem: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(take & mem_v) <= 1);
  // R6: one FP-file write port
  a_r6_fp_port: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(take & fpw_v) <= MAX_FP_WR);
  // R7: a single-issue instruction travels alone
  a_r7_alone: assert property (@(posedge clk) disable iff (!rst_n)
    |(take & solo_v) |-> issue_cnt == 1);
  // R8: nothing issues under a stall window, and a divide opens one
  a_r8_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> issue_cnt == 0);
  a_r8_div_opens: assert property (@(posedge clk) disable iff (!rst_n)
    |(take & div_v) |=> hold);
  // R9: compare-sensitive kinds stay out while the window is open
  a_r9_shy_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    fc_win |-> (take & shy_v) == '0);
  // R10: a condition-code read issues only after its head wait
  a_r10_rd_ready: assert property (@(posedge clk) disable iff (!rst_n)
    |(take & rdcc_v) |-> rd_ready);
endmodule

// File: tb/tb_issue_group_former.sv
`timescale 1ns/1ps
module tb_issue_group_former;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  in_valid;
  logic [15:0] in_cls;
  logic [11:0] in_kind;
  logic [7:0]  in_dst;
  logic [2:0]  issue_cnt;
  logic [11:0] issue_pipe;

  issue_group_former dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_kind(in_kind), .in_dst(in_dst), .issue_cnt(issue_cnt), .issue_pipe(issue_pipe)
  );

  typedef struct packed { logic [3:0] c; logic [2:0] k; logic [1:0] d; } ins_t;
  ins_t q[$];
  int checks = 0, errors = 0, cyc = 0, next_id = 0, dut_seen = 0;
  int issue_at[int];
  string tag = "R12";
  int m_blk = 0, m_fc = 0, m_wait = 0;
  int exp_cnt;
  logic [11:0] exp_pipe;

  function automatic int push(int c, int k, int d);
    ins_t t;
    t.c = 4'(c); t.k = 3'(k); t.d = 2'(d);
    q.push_back(t);
    next_id++;
    return next_id - 1;
  endfunction

  function automatic bit solo(ins_t t);
    return t.c >= 8 || t.k == 2 || t.k == 3 || t.k == 4 || t.k == 5;
  endfunction

  // reference: grows the group one instruction at a time by counting resources
  function automatic void model_group();
    int alu = 0, a0 = 0, a1 = 0, ls = 0, fm = 0, fa = 0, ct = 0, iw = 0, fw = 0;
    bit fcs = (m_fc > 0);
    bit a0busy = 0;
    exp_cnt = 0;
    exp_pipe = '0;
    if (m_blk > 0) return;
    for (int k = 0; k < 4 && k < q.size(); k++) begin
      ins_t t = q[k];
      bit isalu = t.c <= 2;
      bit ismem = (t.c == 5) || (t.c == 6);
      bit lsu = ismem || t.k == 1;
      if (solo(t) && k > 0) break;
      if (t.k == 5 && m_wait < 4) break;
      if ((isalu || ismem) && k == 3) break;
      if (isalu && alu == 2) break;
      if ((t.c == 1 && a0 > 0) || (t.c == 2 && a1 > 0)) break;
      if (lsu && ls > 0) break;
      if ((t.c == 3 && fm > 0) || (t.c == 4 && fa > 0) || (t.c == 7 && ct > 0)) break;
      if ((t.d[0] && iw == 2) || (t.d[1] && fw == 1)) break;
      if ((t.k == 2 || t.k == 3 || t.k == 7) && fcs) break;
      exp_cnt++;
      alu += isalu; a0 += (t.c == 1); a1 += (t.c == 2); ls += lsu;
      fm += (t.c == 3); fa += (t.c == 4); ct += (t.c == 7);
      iw += t.d[0]; fw += t.d[1];
      if (t.k == 6) fcs = 1;
      if (solo(t)) break;
    end
    for (int k = 0; k < exp_cnt; k++) if (q[k].c == 1) a0busy = 1;
    for (int k = 0; k < exp_cnt; k++) begin
      int p;
      case (q[k].c)
        0: begin p = a0busy ? 2 : 1; a0busy = 1; end
        1: p = 1;
        2: p = 2;
        3: p = 4;
        4: p = 5;
        5, 6: p = 3;
        7: p = 6;
        default: p = 1;
      endcase
      exp_pipe[k*3 +: 3] = 3'(p);
    end
  endfunction

  function automatic void model_update();
    int load = 0;
    bit fci = 0, rdi = 0;
    bit head_rd = (q.size() > 0) && (q[0].k == 5);
    for (int i = 0; i < exp_cnt; i++) begin
      if (q[i].k == 2) load = 68;
      if (q[i].k == 3) load = 19;
      if (q[i].k == 4) load = 4;
      if (q[i].k == 6) fci = 1;
      if (q[i].k == 5) rdi = 1;
    end
    if (load > 0) m_blk = load; else if (m_blk > 0) m_blk--;
    if (fci) m_fc = 2; else if (m_fc > 0) m_fc--;
    if (head_rd && !rdi) m_wait = (m_wait < 4) ? m_wait + 1 : 4; else m_wait = 0;
    for (int i = 0; i < exp_cnt; i++) void'(q.pop_front());
  endfunction

  task automatic chk(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    in_valid = '0; in_cls = '0; in_kind = '0; in_dst = '0;
    for (int k = 0; k < 4; k++) if (k < q.size()) begin
      in_valid[k] = 1'b1;
      in_cls[k*4 +: 4] = q[k].c;
      in_kind[k*3 +: 3] = q[k].k;
      in_dst[k*2 +: 2] = q[k].d;
    end
    #1;
    model_group();
    checks++;
    if (issue_cnt !== 3'(exp_cnt) || issue_pipe !== exp_pipe) begin
      errors++;
      $display("FAIL %s cycle %0d: actual cnt %0d pipes %h, expected cnt %0d pipes %h",
               tag, cyc, issue_cnt, issue_pipe, exp_cnt, exp_pipe);
    end
    for (int i = 0; i < int'(issue_cnt); i++) begin
      issue_at[dut_seen] = cyc;
      dut_seen++;
    end
    model_update();
    cyc++;
  endtask

  task automatic run_out(int extra);
    while (q.size() > 0) step();
    for (int i = 0; i < extra; i++) step();
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, b, c2, d2, e;
    in_valid = 4'hF; in_cls = '0; in_kind = '0; in_dst = '0;
    repeat (2) @(negedge clk);
    #1 chk("R12", int'(issue_cnt), 0, "count during reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R12 and R1/R5/R11: a full group straight after reset
    tag = "R12";
    a = push(0, 0, 1); b = push(3, 0, 2); c2 = push(7, 0, 0); d2 = push(4, 0, 0);
    run_out(1);
    chk("R12", issue_at[d2] - issue_at[a], 0, "four issue together after reset");
    chk("R5", issue_at[d2], 0, "FP add at position 3 in cycle 0");

    // R1: a blocked slot is not overtaken
    tag = "R1";
    a = push(1, 0, 1); b = push(1, 0, 1); c2 = push(4, 0, 0);
    run_out(1);
    chk("R1", issue_at[c2] - issue_at[b], 0, "FP add waits behind blocked shift");
    chk("R1", issue_at[b] - issue_at[a], 1, "second ALU0-only in next group");

    // R2: integer class refused at position 3
    tag = "R2";
    a = push(0, 0, 1); b = push(3, 0, 0); c2 = push(4, 0, 0); d2 = push(0, 0, 0);
    run_out(1);
    chk("R2", issue_at[d2] - issue_at[a], 1, "integer at last position deferred");

    // R3: steering and ALU limits
    tag = "R3";
    a = push(0, 0, 0); b = push(1, 0, 0); c2 = push(2, 0, 0);
    push(0, 0, 0); push(0, 0, 0); push(0, 0, 0);
    run_out(1);
    chk("R3", issue_at[b] - issue_at[a], 0, "flexible op pairs with ALU0-only");
    chk("R3", issue_at[c2] - issue_at[a], 1, "third ALU op waits");

    // R4: one memory slot, jump-and-link consumes it
    tag = "R4";
    a = push(5, 0, 1); b = push(6, 0, 0);
    c2 = push(7, 1, 1); d2 = push(5, 0, 1);
    run_out(1);
    chk("R4", issue_at[b] - issue_at[a], 1, "store after load splits");
    chk("R4", issue_at[d2] - issue_at[c2], 1, "load after jump-and-link splits");

    // R5: duplicate branch
    tag = "R5";
    a = push(7, 0, 0); b = push(7, 0, 0);
    run_out(1);
    chk("R5", issue_at[b] - issue_at[a], 1, "second branch splits");

    // R6: write ports
    tag = "R6";
    a = push(0, 0, 1); b = push(0, 0, 1); c2 = push(5, 0, 1);
    d2 = push(3, 0, 2); e = push(4, 0, 2);
    run_out(1);
    chk("R6", issue_at[c2] - issue_at[a], 1, "third integer writer splits");
    chk("R6", issue_at[e] - issue_at[d2], 1, "second FP writer splits");

    // R7: single-issue alone
    tag = "R7";
    a = push(0, 0, 0); b = push(8, 0, 0); c2 = push(0, 0, 0);
    run_out(1);
    chk("R7", issue_at[b] - issue_at[a], 1, "solo not joined at position 1");
    chk("R7", issue_at[c2] - issue_at[b], 1, "solo closes its group");

    // R8: stall windows
    tag = "R8";
    a = push(8, 2, 1); b = push(0, 0, 0);
    run_out(2);
    chk("R8", issue_at[b] - issue_at[a], 69, "divide stall");
    a = push(8, 3, 1); b = push(0, 0, 0);
    run_out(2);
    chk("R8", issue_at[b] - issue_at[a], 20, "multiply stall");
    a = push(8, 4, 0); b = push(0, 0, 0);
    run_out(2);
    chk("R8", issue_at[b] - issue_at[a], 5, "cc write stall");

    // R9: compare window
    tag = "R9";
    a = push(4, 6, 0); b = push(6, 7, 0); c2 = push(0, 0, 0);
    run_out(3);
    chk("R9", issue_at[b] - issue_at[a], 3, "sensitive store after FP compare");
    chk("R9", issue_at[c2] - issue_at[b], 0, "follower issues with the store");

    // R10: condition-code read wait
    tag = "R10";
    a = push(0, 0, 0); b = push(8, 5, 1); c2 = push(8, 5, 1);
    run_out(2);
    chk("R10", issue_at[b] - issue_at[a], 5, "read waits 4 clocks at head");
    chk("R10", issue_at[c2] - issue_at[b], 5, "back-to-back reads each wait");

    // R11: mixed random traffic against the reference model
    tag = "R11";
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 99);
      int kd = (r < 70) ? 0 : (r < 76) ? 1 : (r < 77) ? 2 : (r < 79) ? 3 :
               (r < 82) ? 4 : (r < 85) ? 5 : (r < 92) ? 6 : 7;
      push($urandom_range(0, 8), kd, $urandom_range(0, 3));
      if (q.size() > 8) step();
    end
    run_out(80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule